// File: doc/BRIEF.md
# USB Endpoint Bank Occupancy Tracker

This block follows the buffer banks of a single non-control USB device endpoint that has one, two or three banks. It keeps the index of the bank that software is working on and a count of banks that hold data. For an IN endpoint, a bank counts as busy once software has filled it and until the host has collected it. For an OUT endpoint, a bank counts as busy once the host has filled it and until software has drained it.

Two strobes move the count. A USB-side strobe reports that a bank was filled by an OUT transaction or emptied by an IN transaction, and it takes effect at the next clock edge. A software strobe hands the current bank back. That release runs through a short pipeline, so the count and the bank index change a fixed number of cycles later. While a release is in that pipeline, software access is withheld. A level interrupt reports the whole-bank condition that suits the direction. It is gated by an enable input.

Top module: `ep_bank_tracker`

## Requirements
- R1: After reset, cur_bank is 0 and busy_cnt is 0, so rw_allowed equals dir_in and bank_irq equals int_en AND dir_in.
- R2: A usb_done strobe alone changes busy_cnt at the next clock edge: +1 when dir_in is 0 (OUT fill) and -1 when dir_in is 1 (IN sent).
- R3: A sw_release that is accepted (sampled high while rw_allowed is high) changes busy_cnt (+1 for IN, -1 for OUT) and advances cur_bank exactly REL_DELAY clock edges after the accepting edge (default 2). Neither changes before that.
- R4: cur_bank takes the codes 0, 1 and 2 for banks 0, 1 and 2, never 3. It advances modulo the bank count on each applied release, so code 2 appears only in three-bank mode.
- R5: busy_cnt stays between 0 and the bank count. A usb_done that would move it past either end leaves it unchanged.
- R6: When a usb_done strobe and an applied release fall on the same edge, busy_cnt is unchanged, while cur_bank still advances.
- R7: rw_allowed is high when no release is pending and, for IN, busy_cnt is below the bank count, or, for OUT, busy_cnt is above 0. It is low from the edge after an accepted release until that release is applied.
- R8: A sw_release sampled while rw_allowed is low is ignored: busy_cnt and cur_bank are unchanged afterwards.
- R9: bank_irq is high exactly when int_en is 1 and either dir_in is 1 with busy_cnt 0, or dir_in is 0 with busy_cnt equal to the bank count.
- R10: bank_cfg encodes the bank count as 1, 2 or 3. The code 0 is treated as one bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_in | input | 1 | 1 = IN endpoint, 0 = OUT endpoint |
| bank_cfg | input | 2 | Configured bank count (0 treated as 1) |
| int_en | input | 1 | Bank interrupt enable |
| sw_release | input | 1 | Software hands back the current bank |
| usb_done | input | 1 | USB side filled (OUT) or emptied (IN) a bank |
| cur_bank | output | 2 | Index of the bank software works on |
| busy_cnt | output | 2 | Number of busy banks |
| rw_allowed | output | 1 | Current bank is available to software |
| bank_irq | output | 1 | Whole-bank interrupt, level |

## Verification
A busy count that is off by one shows up on busy_cnt at the edge after the faulty event. Within the same cycle it also moves rw_allowed and bank_irq when the count is at an end of its range. A release pipeline of the wrong length shows up as a busy_cnt or cur_bank change one edge early or late relative to the accepting edge. A wrong modulo shows up on cur_bank after the release that should wrap. A release wrongly accepted while access is withheld shows up as a count or index change two edges later.

// File: rtl/ep_bank_pkg.sv
package ep_bank_pkg;

  localparam int CNT_W = 2;
  typedef logic [CNT_W-1:0] bank_t;

  // bank count from the configuration code; code 0 counts as a single bank
  function automatic bank_t cfg_to_banks(input bank_t cfg);
    return (cfg == '0) ? bank_t'(1) : cfg;
  endfunction

  // next bank index, wrapping modulo the bank count
  function automatic bank_t bank_advance(input bank_t cur, input bank_t nb);
    logic [CNT_W:0] nxt;
    nxt = {1'b0, cur} + 1'b1;
    return (nxt >= {1'b0, nb}) ? '0 : nxt[CNT_W-1:0];
  endfunction

  // saturating busy-count step; simultaneous up and down cancel
  function automatic bank_t busy_step(input bank_t busy, input logic up,
                                      input logic down, input bank_t nb);
    bank_t res;
    res = busy;
    if (up && !down) begin
      if (busy < nb) res = busy + 1'b1;
    end else if (down && !up) begin
      if (busy != '0) res = busy - 1'b1;
    end
    if (res > nb) res = nb;
    return res;
  endfunction

endpackage

// File: rtl/ep_release_pipe.sv
module ep_release_pipe #(
  parameter int DELAY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  output logic pending,
  output logic apply
);
  logic [DELAY-1:0] stg;

  always_ff @(posedge clk) begin
    if (!rst_n) stg[0] <= 1'b0;
    else        stg[0] <= accept;
  end

  for (genvar i = 1; i < DELAY; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stg[i] <= 1'b0;
      else        stg[i] <= stg[i-1];
    end
  end

  assign apply   = stg[DELAY-1];
  assign pending = |stg;
endmodule

// File: rtl/ep_bank_counter.sv
module ep_bank_counter
  import ep_bank_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  dir_in,
  input  bank_t nb,
  input  logic  apply,
  input  logic  usb_done,
  output bank_t cur_bank,
  output bank_t busy_cnt
);
  logic  up_w, down_w;
  bank_t cur_nxt, busy_nxt;

  always_comb begin
    up_w     = dir_in ? apply    : usb_done;
    down_w   = dir_in ? usb_done : apply;
    busy_nxt = busy_step(busy_cnt, up_w, down_w, nb);
    if (cur_bank >= nb)  cur_nxt = '0;
    else if (apply)      cur_nxt = bank_advance(cur_bank, nb);
    else                 cur_nxt = cur_bank;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_bank <= '0;
      busy_cnt <= '0;
    end else begin
      cur_bank <= cur_nxt;
      busy_cnt <= busy_nxt;
    end
  end
endmodule

// File: rtl/ep_bank_status.sv
module ep_bank_status
  import ep_bank_pkg::*;
(
  input  logic  dir_in,
  input  logic  int_en,
  input  bank_t nb,
  input  bank_t busy_cnt,
  input  logic  pending,
  output logic  rw_allowed,
  output logic  bank_irq
);
  logic all_free_w, all_busy_w;

  always_comb begin
    all_free_w = (busy_cnt == '0);
    all_busy_w = (busy_cnt >= nb);
    rw_allowed = !pending && (dir_in ? !all_busy_w : !all_free_w);
    bank_irq   = int_en && (dir_in ? all_free_w : all_busy_w);
  end
endmodule

// File: rtl/ep_bank_tracker.sv
module ep_bank_tracker
  import ep_bank_pkg::*;
#(
  parameter int REL_DELAY = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dir_in,
  input  logic [1:0] bank_cfg,
  input  logic       int_en,
  input  logic       sw_release,
  input  logic       usb_done,
  output logic [1:0] cur_bank,
  output logic [1:0] busy_cnt,
  output logic       rw_allowed,
  output logic       bank_irq
);
  bank_t nb_w;
  logic  accept_w, pending_w, apply_w;

  assign nb_w     = cfg_to_banks(bank_cfg);
  assign accept_w = sw_release && rw_allowed;

  ep_release_pipe #(.DELAY(REL_DELAY)) u_pipe (
    .clk(clk), .rst_n(rst_n), .accept(accept_w),
    .pending(pending_w), .apply(apply_w)
  );

  ep_bank_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .dir_in(dir_in), .nb(nb_w),
    .apply(apply_w), .usb_done(usb_done),
    .cur_bank(cur_bank), .busy_cnt(busy_cnt)
  );

  ep_bank_status u_stat (
    .dir_in(dir_in), .int_en(int_en), .nb(nb_w), .busy_cnt(busy_cnt),
    .pending(pending_w), .rw_allowed(rw_allowed), .bank_irq(bank_irq)
  );
endmodule

// File: rtl/ep_bank_tracker_chk.sv
module ep_bank_tracker_chk
  import ep_bank_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       dir_in,
  input logic [1:0] bank_cfg,
  input logic       int_en,
  input logic       usb_done,
  input logic [1:0] cur_bank,
  input logic [1:0] busy_cnt,
  input logic       rw_allowed,
  input logic       bank_irq,
  input logic       accept_w,
  input logic       apply_w
);
  bank_t nb_c;
  assign nb_c = cfg_to_banks(bank_cfg);

  p_bank_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(bank_cfg) |-> (cur_bank < nb_c));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(bank_cfg) |-> (busy_cnt <= nb_c));

  p_bank_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!apply_w && $stable(bank_cfg)) |=> $stable(cur_bank));

  p_withheld_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> !rw_allowed);

  p_net_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_w && usb_done && $stable(bank_cfg)) |=> $stable(busy_cnt));

  p_usb_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (usb_done && !apply_w && !dir_in && busy_cnt < nb_c && $stable(bank_cfg))
      |=> (busy_cnt == $past(busy_cnt) + 2'd1));

  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bank_irq |-> int_en);
endmodule

bind ep_bank_tracker ep_bank_tracker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dir_in(dir_in), .bank_cfg(bank_cfg),
  .int_en(int_en), .usb_done(usb_done), .cur_bank(cur_bank),
  .busy_cnt(busy_cnt), .rw_allowed(rw_allowed), .bank_irq(bank_irq),
  .accept_w(accept_w), .apply_w(apply_w)
);

// File: tb/ep_bank_tracker_test.sv
`timescale 1ns/1ps
module ep_bank_tracker_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       dir_in;
  logic [1:0] bank_cfg;
  logic       int_en;
  logic       sw_release;
  logic       usb_done;
  logic [1:0] cur_bank;
  logic [1:0] busy_cnt;
  logic       rw_allowed;
  logic       bank_irq;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  ep_bank_tracker uut (
    .clk(clk), .rst_n(rst_n), .dir_in(dir_in), .bank_cfg(bank_cfg),
    .int_en(int_en), .sw_release(sw_release), .usb_done(usb_done),
    .cur_bank(cur_bank), .busy_cnt(busy_cnt), .rw_allowed(rw_allowed),
    .bank_irq(bank_irq)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic d, input logic [1:0] cfg, input logic en);
    dir_in = d; bank_cfg = cfg; int_en = en;
    sw_release = 0; usb_done = 0; rst_n = 0;
    tick(); tick();
    rst_n = 1;
  endtask

  // accepting edge, then two more edges: returns after the update edge
  task automatic release_bank();
    sw_release = 1; tick(); sw_release = 0; tick(); tick();
  endtask

  task automatic usb_pulse();
    usb_done = 1; tick(); usb_done = 0;
  endtask

  task automatic t_reset();
    do_reset(1'b1, 2'd2, 1'b1);
    chk("R1 cur_bank", cur_bank, 0);
    chk("R1 busy_cnt", busy_cnt, 0);
    chk("R1 rw_allowed IN", rw_allowed, 1);
    chk("R1 bank_irq IN", bank_irq, 1);
    do_reset(1'b0, 2'd2, 1'b1);
    chk("R1 rw_allowed OUT", rw_allowed, 0);
    chk("R1 bank_irq OUT", bank_irq, 0);
  endtask

  task automatic t_in_flow();
    do_reset(1'b1, 2'd2, 1'b1);
    sw_release = 1; tick(); sw_release = 0;
    chk("R7 withheld after accept", rw_allowed, 0);
    chk("R3 busy unchanged edge 1", busy_cnt, 0);
    tick();
    chk("R3 busy unchanged edge 2", busy_cnt, 0);
    chk("R3 bank unchanged edge 2", cur_bank, 0);
    tick();
    chk("R3 busy after delay", busy_cnt, 1);
    chk("R4 bank advanced", cur_bank, 1);
    chk("R9 irq off when busy IN", bank_irq, 0);
    chk("R7 rw back after apply", rw_allowed, 1);
    release_bank();
    chk("R3 busy full", busy_cnt, 2);
    chk("R4 wrap two banks", cur_bank, 0);
    chk("R7 rw low when all busy IN", rw_allowed, 0);
    sw_release = 1; tick(); sw_release = 0; tick(); tick(); tick();
    chk("R8 busy after ignored release", busy_cnt, 2);
    chk("R8 bank after ignored release", cur_bank, 0);
    usb_pulse();
    chk("R2 IN sent decrements", busy_cnt, 1);
    usb_pulse(); usb_pulse();
    chk("R5 saturate at 0", busy_cnt, 0);
    chk("R9 irq all free IN", bank_irq, 1);
  endtask

  task automatic t_out_flow();
    do_reset(1'b0, 2'd3, 1'b1);
    sw_release = 1; tick(); sw_release = 0; tick(); tick();
    chk("R8 OUT release while empty", busy_cnt, 0);
    chk("R8 OUT bank unchanged", cur_bank, 0);
    usb_pulse();
    chk("R2 OUT fill increments", busy_cnt, 1);
    chk("R7 rw high OUT busy", rw_allowed, 1);
    usb_pulse(); usb_pulse();
    chk("R2 OUT full", busy_cnt, 3);
    chk("R9 irq all busy OUT", bank_irq, 1);
    usb_pulse();
    chk("R5 saturate at bank count", busy_cnt, 3);
    int_en = 0; #1;
    chk("R9 irq disabled", bank_irq, 0);
    release_bank();
    chk("R3 OUT release decrements", busy_cnt, 2);
    chk("R4 bank 1", cur_bank, 1);
    release_bank();
    chk("R4 bank 2 in three-bank mode", cur_bank, 2);
    release_bank();
    chk("R4 wrap three banks", cur_bank, 0);
    chk("R3 OUT empty", busy_cnt, 0);
  endtask

  task automatic t_simult();
    do_reset(1'b1, 2'd2, 1'b0);
    release_bank();
    chk("R3 setup busy", busy_cnt, 1);
    sw_release = 1; tick(); sw_release = 0; tick();
    usb_done = 1; tick(); usb_done = 0;
    chk("R6 busy net unchanged", busy_cnt, 1);
    chk("R6 bank still advances", cur_bank, 0);
  endtask

  task automatic t_cfg_zero();
    do_reset(1'b1, 2'd0, 1'b1);
    release_bank();
    chk("R10 code 0 one bank full", busy_cnt, 1);
    chk("R10 rw low with one bank", rw_allowed, 0);
    chk("R4 one bank stays 0", cur_bank, 0);
  endtask

  initial begin
    #500000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_in_flow();
    t_out_flow();
    t_simult();
    t_cfg_zero();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule